// File: doc/BRIEF.md
# Twelve-Source Two-Level Interrupt Controller

This block sits next to an 8-bit controller core and decides which of twelve interrupt sources is serviced next. Four of the sources are request levels from logic elsewhere on the chip: external inputs 0 and 1, and the overflow flags of timers 0 and 1. The other eight are port pins (external inputs 2 to 9). Each pin has its own polarity bit and a sticky request flag. Software clears the flag, and a pin that is still active sets it again.

Each source has an enable bit and one priority bit, and one global enable gates all of them. Among the enabled requests the controller picks a winner. A high-priority request beats a low-priority one. Within one level a fixed interleaved order settles ties. The winner's vector address is registered and offered to the core. The core acknowledges the vector, and a return pulse later retires the routine. The controller tracks two nesting levels, so a high-priority request can interrupt a low-priority routine.

A separate combinational wake output flags an enabled, active port input. It works with the clock stopped, so the device can leave power-down.

Top module: `irq12_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every configuration register, every request flag and both in-service levels are 0, and `irq_valid` is 0.
- R2: Configuration writes use `cfg_addr`: 0 enables core sources (bit 7 global enable, bit 0 ext0, bit 1 timer0, bit 2 ext1, bit 3 timer1); 1 enables ext2..ext9 in bits 0..7; 2 sets core priorities in bits 0..3 (same bit order); 3 sets ext2..ext9 priorities in bits 0..7; 4 sets polarity; 5 writes the flags. A source competes only while both its own enable and the global enable are 1.
- R3: A port input is active when its pin equals its polarity bit (0 = active low, 1 = active high). An active input sets its flag at the next clock edge, whether or not it is enabled.
- R4: A flag stays set until a write to address 5 clears it, and it is set again if its input is still active in the cycle of that write.
- R5: Within one priority level, ties resolve in the order ext0, ext5, timer0, ext6, ext1, ext2, ext7, timer1, ext3, ext8, ext4, ext9, from highest to lowest.
- R6: The vector is 0003H, 000BH, 0013H, 001BH for ext0, timer0, ext1, timer1, and 003BH + 8*(n-2) for ext n (n = 2..9), ending at 0073H.
- R7: A pending high-priority request (priority bit 1) wins over every low-priority request, whatever their places in the tie order.
- R8: While a low-priority routine is in service, only high-priority requests are offered. While a high-priority routine is in service, nothing is offered.
- R9: A `ret_pulse` clears the high in-service level if it is set, and otherwise clears the low one.
- R10: `irq_valid`, `irq_vec` and `irq_high` are registered from the state of the previous cycle. `irq_ack` while `irq_valid` is 1 marks that level in service and drops `irq_valid` at the next edge.
- R11: `wake` is 1 combinationally whenever a port input is active and its enable bit in register 1 is 1, regardless of the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| core_req | input | 4 | Request levels: ext0, timer0, ext1, timer1 in bits 0..3 |
| port_pin | input | 8 | Port inputs ext2..ext9 in bits 0..7 |
| irq_ack | input | 1 | Core has taken the offered vector |
| ret_pulse | input | 1 | Return from the current service routine |
| irq_valid | output | 1 | A vector is offered |
| irq_vec | output | 16 | Offered vector address |
| irq_high | output | 1 | Offered request is high priority |
| port_flags | output | 8 | Request flags of ext2..ext9 |
| wake | output | 1 | Wake request from an enabled active port input |

## Verification
The assertions check on every cycle the rules that hold regardless of the scenario. An active pin always sets its flag, and a flag never drops without a write. No vector is offered while the global enable is off or a high-priority routine is in service, and a low-priority routine only sees high-priority offers. An acknowledge always drops the offer, and a return pulse retires the right level. Only the bench's scenarios can show that the tie order and the vector addresses are right. The same holds for preemption across full acknowledge and return sequences, and for a flag re-arming when it is cleared while its pin is still active. There a behavioural model is compared with the outputs every cycle and against literal vector values.

// File: rtl/irq12_pkg.sv
// Shared constants and helpers for the twelve-source interrupt controller.
// Source numbering used throughout: 0 ext0, 1 timer0, 2 ext1, 3 timer1,
// 4..11 ext2..ext9. Assumes the vector layout 0003H + 8 * code.
package irq12_pkg;
    localparam int NCORE = 4;
    localparam int NPORT = 8;
    localparam int NSRC  = NCORE + NPORT;
    localparam int SRCW  = $clog2(NSRC);
    localparam int VECW  = 16;
    localparam int VEC_BASE = 3;
    localparam int VEC_STEP = 8;
    localparam int PORT_CODE_OFS = 3;

    // Source number that holds place k (0 = highest) in the tie order.
    function automatic int unsigned rank_src(int unsigned k);
        case (k)
            0:  return 0;
            1:  return 7;
            2:  return 1;
            3:  return 8;
            4:  return 2;
            5:  return 4;
            6:  return 9;
            7:  return 3;
            8:  return 5;
            9:  return 10;
            10: return 6;
            default: return 11;
        endcase
    endfunction

    // Vector address of a source number.
    function automatic logic [VECW-1:0] src_vector(logic [SRCW-1:0] s);
        int unsigned code;
        code = (int'(s) < NCORE) ? int'(s) : int'(s) + PORT_CODE_OFS;
        return VECW'(VEC_BASE + VEC_STEP * code);
    endfunction
endpackage

// File: rtl/irq12_cfg.sv
// Configuration register file: enables, priorities, polarity.
// Assumes single-cycle writes; the flag register lives in irq12_portflags,
// so this block only decodes its write strobe.
module irq12_cfg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] en_core,
    output logic [DW-1:0] en_port,
    output logic [DW-1:0] pri_core,
    output logic [DW-1:0] pri_port,
    output logic [DW-1:0] pol_port,
    output logic          flag_we
);
    localparam logic [2:0] A_EN_CORE  = 3'd0;
    localparam logic [2:0] A_EN_PORT  = 3'd1;
    localparam logic [2:0] A_PRI_CORE = 3'd2;
    localparam logic [2:0] A_PRI_PORT = 3'd3;
    localparam logic [2:0] A_POL      = 3'd4;
    localparam logic [2:0] A_FLAGS    = 3'd5;

    // Register writes, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_core  <= '0;
            en_port  <= '0;
            pri_core <= '0;
            pri_port <= '0;
            pol_port <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                A_EN_CORE:  en_core  <= cfg_wdata;
                A_EN_PORT:  en_port  <= cfg_wdata;
                A_PRI_CORE: pri_core <= cfg_wdata;
                A_PRI_PORT: pri_port <= cfg_wdata;
                A_POL:      pol_port <= cfg_wdata;
                default: ;
            endcase
        end
    end

    // Strobe for the flag register held elsewhere.
    assign flag_we = cfg_we && (cfg_addr == A_FLAGS);
endmodule

// File: rtl/irq12_portflags.sv
// Port input conditioning: polarity compare, sticky request flags, wake.
// Assumes pins are already synchronous to clk; wake is combinational so it
// can be used while the clock is stopped.
module irq12_portflags #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] en,
    input  logic         flag_we,
    input  logic [W-1:0] flag_wdata,
    output logic [W-1:0] flags,
    output logic         wake
);
    logic [W-1:0] active;

    // An input is active when the pin level equals its polarity bit.
    assign active = ~(pins ^ pol);

    // Wake on any enabled active input.
    assign wake = |(active & en);

    // Sticky flags: software write replaces, active inputs set on top.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flag_we ? flag_wdata : flags) | active;
    end

    for (genvar i = 0; i < W; i++) begin : g_chk
        a_r3_active_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
            active[i] |=> flags[i]);
        a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !flag_we) |=> flags[i]);
    end
endmodule

// File: rtl/irq12_pick.sv
// Two-level fixed-order arbiter. For each priority level it finds the
// enabled request that comes first in the tie order. Purely combinational.
module irq12_pick
    import irq12_pkg::*;
(
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] prio,
    output logic            hi_any,
    output logic [SRCW-1:0] hi_src,
    output logic            lo_any,
    output logic [SRCW-1:0] lo_src
);
    for (genvar lvl = 0; lvl < 2; lvl++) begin : g_lvl
        logic [NSRC-1:0] lvl_req;
        logic            any_g;
        logic [SRCW-1:0] src_g;

        assign lvl_req = req & ((lvl == 1) ? prio : ~prio);

        // Scan from the lowest place upward so the highest place wins last.
        always_comb begin
            any_g = 1'b0;
            src_g = '0;
            for (int k = NSRC - 1; k >= 0; k--) begin
                if (lvl_req[rank_src(k)]) begin
                    any_g = 1'b1;
                    src_g = SRCW'(rank_src(k));
                end
            end
        end
    end

    assign hi_any = g_lvl[1].any_g;
    assign hi_src = g_lvl[1].src_g;
    assign lo_any = g_lvl[0].any_g;
    assign lo_src = g_lvl[0].src_g;
endmodule

// File: rtl/irq12_nest.sv
// Nesting tracker and vector register. Decides whether the winners may be
// offered given the in-service levels, registers the offer, and updates the
// in-service levels on acknowledge and return. Assumes ack and return are
// single-cycle pulses from the core.
module irq12_nest
    import irq12_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hi_any,
    input  logic [SRCW-1:0] hi_src,
    input  logic            lo_any,
    input  logic [SRCW-1:0] lo_src,
    input  logic            ack,
    input  logic            ret,
    output logic            irq_valid,
    output logic [VECW-1:0] irq_vec,
    output logic            irq_high
);
    logic            in_lo, in_hi;
    logic            take_hi, take_lo, cand, accept;
    logic [SRCW-1:0] cand_src;

    // Offer rules: high may preempt low, nothing preempts high.
    always_comb begin
        take_hi  = !in_hi && hi_any;
        take_lo  = !in_hi && !in_lo && lo_any && !hi_any;
        cand     = take_hi || take_lo;
        cand_src = take_hi ? hi_src : lo_src;
        accept   = ack && irq_valid;
    end

    // Registered offer; dropped for one cycle after an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_vec   <= '0;
            irq_high  <= 1'b0;
        end else begin
            irq_valid <= cand && !accept;
            if (cand) begin
                irq_vec  <= src_vector(cand_src);
                irq_high <= take_hi;
            end
        end
    end

    // In-service levels: return retires the newest, acknowledge opens one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_lo <= 1'b0;
            in_hi <= 1'b0;
        end else begin
            if (accept && irq_high)       in_hi <= 1'b1;
            else if (ret && in_hi)        in_hi <= 1'b0;
            if (accept && !irq_high)      in_lo <= 1'b1;
            else if (ret && !in_hi)       in_lo <= 1'b0;
        end
    end

    a_r8_high_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
        in_hi |=> !irq_valid);
    a_r8_low_only_high: assert property (@(posedge clk) disable iff (!rst_n)
        in_lo |=> (!irq_valid || irq_high));
    a_r10_ack_drops_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && ack) |=> !irq_valid);
    a_r10_hi_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_hi) |-> $past(irq_valid && irq_high && ack));
    a_r9_ret_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && in_hi && !ack) |=> !in_hi);
    a_r9_ret_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !in_hi && in_lo && !ack) |=> !in_lo);
endmodule

// File: rtl/irq12_ctrl.sv
// Top of the twelve-source two-level interrupt controller. Gathers the
// request vector, applies enables and the global gate, and feeds the
// arbiter and nesting tracker. Assumes core request levels are cleared by
// their owners.
module irq12_ctrl
    import irq12_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [7:0]       cfg_wdata,
    input  logic [NCORE-1:0] core_req,
    input  logic [NPORT-1:0] port_pin,
    input  logic             irq_ack,
    input  logic             ret_pulse,
    output logic             irq_valid,
    output logic [VECW-1:0]  irq_vec,
    output logic             irq_high,
    output logic [NPORT-1:0] port_flags,
    output logic             wake
);
    localparam int GLOBAL_BIT = 7;

    logic [7:0]      en_core, en_port, pri_core, pri_port, pol_port;
    logic            flag_we;
    logic [NSRC-1:0] pend, en_all, pri_all, req;
    logic            hi_any, lo_any;
    logic [SRCW-1:0] hi_src, lo_src;

    irq12_cfg #(.DW(8)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .en_core(en_core), .en_port(en_port),
        .pri_core(pri_core), .pri_port(pri_port), .pol_port(pol_port),
        .flag_we(flag_we)
    );

    irq12_portflags #(.W(NPORT)) u_flags (
        .clk(clk), .rst_n(rst_n), .pins(port_pin), .pol(pol_port),
        .en(en_port), .flag_we(flag_we), .flag_wdata(cfg_wdata),
        .flags(port_flags), .wake(wake)
    );

    // Request vector in source numbering, gated by enables.
    always_comb begin
        pend    = {port_flags, core_req};
        en_all  = {en_port, en_core[NCORE-1:0]};
        pri_all = {pri_port, pri_core[NCORE-1:0]};
        req     = en_core[GLOBAL_BIT] ? (pend & en_all) : '0;
    end

    irq12_pick u_pick (
        .req(req), .prio(pri_all), .hi_any(hi_any), .hi_src(hi_src),
        .lo_any(lo_any), .lo_src(lo_src)
    );

    irq12_nest u_nest (
        .clk(clk), .rst_n(rst_n), .hi_any(hi_any), .hi_src(hi_src),
        .lo_any(lo_any), .lo_src(lo_src), .ack(irq_ack), .ret(ret_pulse),
        .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_high(irq_high)
    );

    a_r2_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !en_core[GLOBAL_BIT] |=> !irq_valid);
    a_r2_no_request_no_offer: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_req == '0) && (port_flags == '0)) |=> !irq_valid);
endmodule

// File: tb/irq12_ctrl_tb.sv
module irq12_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [3:0]  core_req = '0;
    logic [7:0]  port_pin = 8'hFF;
    logic        irq_ack = 1'b0;
    logic        ret_pulse = 1'b0;
    logic        irq_valid;
    logic [15:0] irq_vec;
    logic        irq_high;
    logic [7:0]  port_flags;
    logic        wake;

    irq12_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .core_req(core_req), .port_pin(port_pin),
        .irq_ack(irq_ack), .ret_pulse(ret_pulse), .irq_valid(irq_valid),
        .irq_vec(irq_vec), .irq_high(irq_high), .port_flags(port_flags),
        .wake(wake)
    );

    always #10 clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    done  = 0;
    string cur   = "R1";

    // Behavioural reference state.
    bit [7:0] m_en0, m_en1, m_pri0, m_pri1, m_pol, m_flag;
    bit       m_lo, m_hi, m_valid, m_high;
    int       m_vec;
    int       tie_order[12] = '{0, 7, 1, 8, 2, 4, 9, 3, 5, 10, 6, 11};
    int       vec_tab[12]   = '{'h03, 'h0B, 'h13, 'h1B, 'h3B, 'h43, 'h4B,
                                'h53, 'h5B, 'h63, 'h6B, 'h73};

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp=<20000", cyc);
            report();
        end
    end

    task automatic model_reset();
        m_en0 = 0; m_en1 = 0; m_pri0 = 0; m_pri1 = 0; m_pol = 0; m_flag = 0;
        m_lo = 0; m_hi = 0; m_valid = 0; m_high = 0; m_vec = 0;
    endtask

    task automatic model_step();
        bit [11:0] pend, en, pr, rq;
        bit [7:0]  act;
        int        hs, ls, win;
        bit        take, cand, chi;
        bit        nlo, nhi;
        pend = {m_flag, core_req};
        en   = {m_en1, m_en0[3:0]};
        pr   = {m_pri1, m_pri0[3:0]};
        rq   = m_en0[7] ? (pend & en) : 12'h0;
        hs = -1; ls = -1;
        for (int k = 0; k < 12; k++) begin
            if (rq[tie_order[k]] && pr[tie_order[k]] && hs < 0) hs = tie_order[k];
            if (rq[tie_order[k]] && !pr[tie_order[k]] && ls < 0) ls = tie_order[k];
        end
        cand = 0; chi = 0; win = 0;
        if (!m_hi && hs >= 0) begin cand = 1; chi = 1; win = hs; end
        else if (!m_hi && !m_lo && ls >= 0) begin cand = 1; win = ls; end
        take = irq_ack && m_valid;
        nlo = m_lo; nhi = m_hi;
        if (ret_pulse) begin
            if (nhi) nhi = 0; else nlo = 0;
        end
        if (take) begin
            if (m_high) nhi = 1; else nlo = 1;
        end
        act = ~(port_pin ^ m_pol);
        m_flag = ((cfg_we && cfg_addr == 5) ? cfg_wdata : m_flag) | act;
        if (cfg_we) begin
            case (cfg_addr)
                0: m_en0 = cfg_wdata;
                1: m_en1 = cfg_wdata;
                2: m_pri0 = cfg_wdata;
                3: m_pri1 = cfg_wdata;
                4: m_pol = cfg_wdata;
                default: ;
            endcase
        end
        if (cand) begin m_vec = vec_tab[win]; m_high = chi; end
        m_valid = cand && !take;
        m_lo = nlo; m_hi = nhi;
    endtask

    task automatic compare();
        n_chk++;
        if (irq_valid !== m_valid || port_flags !== m_flag ||
            (m_valid && (irq_vec !== 16'(m_vec) || irq_high !== m_high))) begin
            n_bad++;
            $display("FAIL %s cyc %0d: act v=%0b vec=%h hi=%0b fl=%h exp v=%0b vec=%h hi=%0b fl=%h",
                     cur, cyc, irq_valid, irq_vec, irq_high, port_flags,
                     m_valid, 16'(m_vec), m_high, m_flag);
        end
    endtask

    task automatic check_wake_model();
        bit exp;
        exp = |(~(port_pin ^ m_pol) & m_en1);
        n_chk++;
        if (wake !== exp) begin
            n_bad++;
            $display("FAIL %s wake: act=%0b exp=%0b", cur, wake, exp);
        end
    endtask

    // One clock: wake check, edge, model update, compare at the falling edge.
    task automatic tk(int n);
        for (int i = 0; i < n; i++) begin
            #1 check_wake_model();
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare();
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        tk(1);
        cfg_we = 0;
    endtask

    task automatic pulse_ack();
        irq_ack = 1; tk(1); irq_ack = 0;
    endtask

    task automatic pulse_ret();
        ret_pulse = 1; tk(1); ret_pulse = 0;
    endtask

    task automatic exp_vec(logic [15:0] v, logic hi);
        n_chk++;
        if (irq_valid !== 1'b1 || irq_vec !== v || irq_high !== hi) begin
            n_bad++;
            $display("FAIL %s vector: act v=%0b vec=%h hi=%0b exp v=1 vec=%h hi=%0b",
                     cur, irq_valid, irq_vec, irq_high, v, hi);
        end
    endtask

    task automatic exp_idle();
        n_chk++;
        if (irq_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL %s offer: act v=%0b exp v=0", cur, irq_valid);
        end
    endtask

    task automatic exp_flags(logic [7:0] f);
        n_chk++;
        if (port_flags !== f) begin
            n_bad++;
            $display("FAIL %s flags: act=%h exp=%h", cur, port_flags, f);
        end
    endtask

    task automatic exp_wake(logic w);
        #1;
        n_chk++;
        if (wake !== w) begin
            n_bad++;
            $display("FAIL %s wake: act=%0b exp=%0b", cur, wake, w);
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        cur = "R1";
        exp_idle(); exp_flags(8'h00);
        tk(2);

        // R2: enables and global gate
        cur = "R2";
        core_req = 4'b0001;
        tk(2); exp_idle();
        wr(0, 8'h01); tk(2); exp_idle();
        wr(0, 8'h81); tk(1);
        cur = "R6"; exp_vec(16'h0003, 0);
        cur = "R10"; pulse_ack(); exp_idle();
        core_req = 4'b0000; tk(1);
        cur = "R9"; pulse_ret(); tk(1);

        // R3: polarity and flag setting
        cur = "R3";
        wr(1, 8'h01);
        port_pin = 8'hFE; tk(1); port_pin = 8'hFF;
        exp_flags(8'h01);
        tk(1);
        cur = "R6"; exp_vec(16'h003B, 0);
        pulse_ack(); wr(5, 8'h00); pulse_ret();
        cur = "R3";
        wr(4, 8'h80); tk(1); exp_flags(8'h80);
        port_pin = 8'h7F;
        // R4: sticky flag, clear, re-arm
        cur = "R4";
        wr(5, 8'h00); tk(1); exp_flags(8'h00);
        port_pin = 8'hFF; tk(1); port_pin = 8'h7F; tk(3);
        exp_flags(8'h80);
        port_pin = 8'hFF; wr(5, 8'h00); exp_flags(8'h80);
        port_pin = 8'h7F; wr(5, 8'h00); exp_flags(8'h00);
        wr(4, 8'h00); port_pin = 8'hFF; tk(1); wr(5, 8'h00); tk(1);

        // R11: wake ignores the global enable
        cur = "R11";
        wr(0, 8'h00);
        port_pin = 8'hFE; exp_wake(1); tk(1);
        port_pin = 8'hFD; exp_wake(0); tk(1);
        port_pin = 8'hFF; wr(5, 8'h00); tk(1); exp_idle();

        // R5: tie order within the low level
        cur = "R5";
        wr(1, 8'hFF); wr(0, 8'h8F);
        core_req = 4'b0010; port_pin = 8'hF7; tk(1); port_pin = 8'hFF;
        tk(1); exp_vec(16'h0053, 0);
        pulse_ack(); wr(5, 8'h00); pulse_ret(); tk(1);
        exp_vec(16'h000B, 0);
        pulse_ack(); core_req = 4'b0000; pulse_ret(); tk(1);
        port_pin = 8'h7B; tk(1); port_pin = 8'hFF; tk(1);
        exp_vec(16'h004B, 0);
        pulse_ack(); wr(5, 8'h80); pulse_ret(); tk(1);
        cur = "R6"; exp_vec(16'h0073, 0);
        pulse_ack(); wr(5, 8'h00); pulse_ret(); tk(1);

        // R7: high level beats an earlier low-level source
        cur = "R7";
        wr(3, 8'h80);
        core_req = 4'b0001; port_pin = 8'h7F; tk(1); port_pin = 8'hFF; tk(1);
        exp_vec(16'h0073, 1);
        pulse_ack();
        // R8: nothing preempts a high routine
        cur = "R8";
        tk(3); exp_idle();
        wr(5, 8'h00);
        cur = "R9"; pulse_ret(); tk(1);
        exp_vec(16'h0003, 0);
        pulse_ack();
        cur = "R8";
        core_req = 4'b0101; tk(2); exp_idle();
        wr(2, 8'h02); core_req = 4'b0111; tk(2);
        exp_vec(16'h000B, 1);
        pulse_ack(); tk(2); exp_idle();
        core_req = 4'b0100;
        cur = "R9"; pulse_ret(); tk(1); exp_idle();
        pulse_ret(); tk(1);
        exp_vec(16'h0013, 0);
        pulse_ack(); core_req = 4'b0000; pulse_ret(); tk(2); exp_idle();

        report();
    end
endmodule